// File: doc/BRIEF.md
# EDO DRAM Page Controller

This block sits between a simple host request port and an asynchronous EDO DRAM with a 16-bit data bus. The host offers one request at a time: a 22-bit word address, a read/write flag, two byte-enable bits and write data. A valid/ready handshake accepts it. The controller splits the address into a 12-bit row (bits 21:10) and a 10-bit column (bits 9:0) and drives them in turn on one shared 12-bit address bus. It then sequences the row strobe, two byte column strobes, write enable and output enable. Read data returns on `rdata` with a one-cycle `rdata_valid` pulse.

After an access the row stays open. A later request to the same row is served as a page cycle, with only a column strobe and no new row strobe. Reads and writes may be mixed freely within the page. A request to another row, or a pending refresh, closes the page. Every analog delay is a parameter in nanoseconds, rounded up to whole clock cycles at the configured clock period. A separate block asks for refresh with `ref_req`. The controller closes any open page, runs a CAS-before-RAS refresh and answers with a one-cycle `ref_gnt`.

The controller has these states. IDLE: no row is open. ROW: the row address is set up with RAS high, for one cycle. RCD: RAS is low, for the RAS-to-column delay. CSET: the column is driven, and for writes so are WE and the data, for one cycle. CAS: the byte strobes are low for the access time. CPRE: the column strobes precharge. PAGE: the row stays open and waits. PRE: RAS precharges. RCAS: both CAS go low with RAS high, for one cycle. RRAS: the refresh RAS pulse.

The transitions are: IDLE→RCAS on a refresh request; IDLE→ROW on an accepted request; ROW→RCD; RCD→CSET; CSET→CAS; CAS→CPRE; CPRE→PAGE; PAGE→CSET on an accepted request to the same row; PAGE→PRE on a request to another row or a refresh, once the minimum RAS-low time is met; PRE→IDLE; RCAS→RRAS; RRAS→PRE when the minimum RAS-low time is met.

Top module: `edo_page_ctrl`

## Requirements
- R1: During and after reset, with no request pending, RAS, both CAS lines, WE and OE are high, `dram_dq_oe` is 0, `rdata_valid` is 0 and `req_ready` is 1.
- R2: The row `req_addr[21:10]` is on `dram_a` when RAS falls. The column `{2'b00, req_addr[9:0]}` is on `dram_a` when CAS falls. `dram_a` and WE do not change while any CAS line is low.
- R3: `req_be[0]` selects the lower CAS (data bits 7:0) and `req_be[1]` selects the upper CAS (bits 15:8). Only the enabled strobes go low. Bytes of a disabled lane are not written, and they read back as zero.
- R4: For a write, WE is low and the write data are driven at least one cycle before CAS falls, and stay until CAS rises. `dram_dq_oe` is never 1 while OE is low.
- R5: For a read, WE stays high and OE is low while CAS is low. CAS stays low for ceil(tAA/clock) cycles, which is 4 at the defaults. The data are sampled in the last of those cycles and returned with a one-cycle `rdata_valid` pulse.
- R6: RAS stays low at least ceil(tRAS/clock) cycles (7) and high at least ceil(tRP/clock) cycles (4) before it falls again. CAS first falls at least ceil((tRAC-tAA)/clock)+1 cycles (5) after RAS falls.
- R7: A request to the open row is served without RAS rising, and reads and writes can be mixed within the page.
- R8: A request to another row keeps `req_ready` low until the page is closed and precharged. It then opens the new row with one RAS fall.
- R9: While `ref_req` is high, `req_ready` is 0. The controller closes any page, lowers both CAS lines one cycle before RAS falls, keeps WE and OE high and the data bus undriven, and pulses `ref_gnt` for one cycle in the cycle before RAS rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in 21:10, column in 9:0 |
| req_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, disabled bytes zero |
| rdata_valid | output | 1 | One-cycle read return pulse |
| ref_req | input | 1 | Refresh request, held until grant |
| ref_gnt | output | 1 | One-cycle refresh done pulse |
| dram_a | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven to the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data returned from the memory |

## Verification
A state register that has gone wrong shows up at the strobe pins within one or two cycles. It can show as a CAS fall with RAS high but without both lanes low, as a RAS pulse shorter than its minimum, or as an address change under a low CAS. A wrong open-row register shows up only at the next page hit: the column lands in the wrong row, and the scoreboard sees a wrong read-back word four to six cycles after the CAS fall. A wrong timer shows up as a CAS width or a precharge gap that differs from the rounded cycle counts. It is seen when CAS or RAS next rises.

// File: rtl/edo_page_pkg.sv
package edo_page_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_RCD,
        ST_CSET,
        ST_CAS,
        ST_CPRE,
        ST_PAGE,
        ST_PRE,
        ST_RCAS,
        ST_RRAS
    } edo_state_e;

    // Round a delay in ns up to whole cycles, never less than one.
    function automatic int cycles_of(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/edo_cycle_timer.sv
module edo_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/edo_byte_lanes.sv
module edo_byte_lanes #(
    parameter int LANES = 2
) (
    input  logic               strobe,
    input  logic [LANES-1:0]   be,
    output logic [LANES-1:0]   cas_n,
    output logic [LANES*8-1:0] data_mask
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign cas_n[i]          = ~(strobe & be[i]);
        assign data_mask[i*8 +: 8] = {8{be[i]}};
    end
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
    import edo_page_pkg::*;
#(
    parameter int CLK_NS   = 8,
    parameter int T_RAC_NS = 50,
    parameter int T_AA_NS  = 25,
    parameter int T_RAS_NS = 50,
    parameter int T_RP_NS  = 30,
    parameter int T_CP_NS  = 8,
    parameter int ROW_W    = 12,
    parameter int COL_W    = 10,
    parameter int DW       = 16,
    parameter int TMR_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DW/8-1:0]        req_be,
    input  logic [DW-1:0]          req_wdata,
    output logic [DW-1:0]          rdata,
    output logic                   rdata_valid,
    input  logic                   ref_req,
    output logic                   ref_gnt,
    output logic [ROW_W-1:0]       dram_a,
    output logic                   dram_ras_n,
    output logic                   dram_lcas_n,
    output logic                   dram_ucas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [DW-1:0]          dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DW-1:0]          dram_dq_in
);
    localparam int LANES   = DW / 8;
    localparam int CAS_CYC = cycles_of(T_AA_NS, CLK_NS);
    localparam int RCD_CYC = cycles_of(T_RAC_NS - T_AA_NS, CLK_NS);
    localparam int RAS_CYC = cycles_of(T_RAS_NS, CLK_NS);
    localparam int RP_CYC  = cycles_of(T_RP_NS, CLK_NS);
    localparam int CP_CYC  = cycles_of(T_CP_NS, CLK_NS);

    edo_state_e state, nxt;

    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;
    logic [LANES-1:0] cur_be;
    logic             cur_wr;
    logic [DW-1:0]    cur_wdata;

    logic             tmr_load, tmr_done, ras_load, ras_done;
    logic [TMR_W-1:0] tmr_val;
    logic             lane_strobe;
    logic [LANES-1:0] lane_cas_n;
    logic [DW-1:0]    lane_mask;
    logic             accept;

    wire [ROW_W-1:0] req_row = req_addr[ROW_W+COL_W-1:COL_W];
    wire [COL_W-1:0] req_col = req_addr[COL_W-1:0];

    edo_cycle_timer #(.W(TMR_W)) u_step_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    edo_cycle_timer #(.W(TMR_W)) u_ras_tmr (
        .clk(clk), .rst_n(rst_n), .load(ras_load),
        .load_val(TMR_W'(RAS_CYC - 1)), .done(ras_done)
    );

    edo_byte_lanes #(.LANES(LANES)) u_lanes (
        .strobe(lane_strobe), .be(cur_be), .cas_n(lane_cas_n), .data_mask(lane_mask)
    );

    assign req_ready = !ref_req &&
                       (state == ST_IDLE || (state == ST_PAGE && req_row == cur_row));
    assign accept    = req_valid && req_ready;

    // Next state and timer loads
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ras_load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ref_req)        nxt = ST_RCAS;
                else if (req_valid) nxt = ST_ROW;
            end
            ST_ROW: begin
                nxt      = ST_RCD;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(RCD_CYC - 1);
                ras_load = 1'b1;
            end
            ST_RCD:  if (tmr_done) nxt = ST_CSET;
            ST_CSET: begin
                nxt      = ST_CAS;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(CAS_CYC - 1);
            end
            ST_CAS: if (tmr_done) begin
                nxt      = ST_CPRE;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(CP_CYC - 1);
            end
            ST_CPRE: if (tmr_done) nxt = ST_PAGE;
            ST_PAGE: begin
                if (accept)
                    nxt = ST_CSET;
                else if ((ref_req || req_valid) && ras_done) begin
                    nxt      = ST_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(RP_CYC - 1);
                end
            end
            ST_PRE:  if (tmr_done) nxt = ST_IDLE;
            ST_RCAS: begin
                nxt      = ST_RRAS;
                ras_load = 1'b1;
            end
            ST_RRAS: if (ras_done) begin
                nxt      = ST_PRE;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(RP_CYC - 1);
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cur_row     <= '0;
            cur_col     <= '0;
            cur_be      <= '0;
            cur_wr      <= 1'b0;
            cur_wdata   <= '0;
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            state       <= nxt;
            rdata_valid <= 1'b0;
            if (accept) begin
                if (state == ST_IDLE) cur_row <= req_row;
                cur_col   <= req_col;
                cur_be    <= req_be;
                cur_wr    <= req_write;
                cur_wdata <= req_wdata;
            end
            if (state == ST_CAS && tmr_done && !cur_wr) begin
                rdata       <= dram_dq_in & lane_mask;
                rdata_valid <= 1'b1;
            end
        end
    end

    // Pin outputs decoded from the state
    always_comb begin
        dram_ras_n  = 1'b1;
        dram_we_n   = 1'b1;
        dram_oe_n   = 1'b1;
        dram_dq_oe  = 1'b0;
        lane_strobe = 1'b0;
        ref_gnt     = 1'b0;
        dram_a      = ROW_W'(cur_col);
        dram_lcas_n = lane_cas_n[0];
        dram_ucas_n = lane_cas_n[LANES-1];
        unique case (state)
            ST_IDLE, ST_ROW, ST_PRE: dram_a = cur_row;
            ST_RCD: begin
                dram_ras_n = 1'b0;
                dram_a     = cur_row;
            end
            ST_CSET: begin
                dram_ras_n = 1'b0;
                dram_we_n  = !cur_wr;
                dram_dq_oe = cur_wr;
            end
            ST_CAS: begin
                dram_ras_n  = 1'b0;
                lane_strobe = 1'b1;
                dram_we_n   = !cur_wr;
                dram_dq_oe  = cur_wr;
                dram_oe_n   = cur_wr;
                dram_lcas_n = lane_cas_n[0];
                dram_ucas_n = lane_cas_n[LANES-1];
            end
            ST_CPRE, ST_PAGE: dram_ras_n = 1'b0;
            ST_RCAS: begin
                dram_lcas_n = 1'b0;
                dram_ucas_n = 1'b0;
            end
            ST_RRAS: begin
                dram_ras_n  = 1'b0;
                dram_lcas_n = 1'b0;
                dram_ucas_n = 1'b0;
                ref_gnt     = ras_done;
            end
            default: dram_ras_n = 1'b1;
        endcase
    end

    assign dram_dq_out = cur_wdata;
endmodule

// File: rtl/edo_page_ctrl_checker.sv
module edo_page_ctrl_checker #(
    parameter int RAS_CYC = 7,
    parameter int RP_CYC  = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        dram_ras_n,
    input logic        dram_lcas_n,
    input logic        dram_ucas_n,
    input logic        dram_we_n,
    input logic        dram_oe_n,
    input logic        dram_dq_oe,
    input logic [11:0] dram_a,
    input logic        rdata_valid,
    input logic        ref_req,
    input logic        ref_gnt,
    input logic        req_ready
);
    logic [7:0] low_cnt, high_cnt;
    wire cas_any  = !dram_lcas_n || !dram_ucas_n;
    wire cas_both = !dram_lcas_n && !dram_ucas_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= 8'(RP_CYC);
        end else if (dram_ras_n) begin
            low_cnt  <= '0;
            high_cnt <= (high_cnt == 8'hFF) ? high_cnt : high_cnt + 1'b1;
        end else begin
            high_cnt <= '0;
            low_cnt  <= (low_cnt == 8'hFF) ? low_cnt : low_cnt + 1'b1;
        end
    end

    a_r6_ras_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> low_cnt >= 8'(RAS_CYC));

    a_r6_ras_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> high_cnt >= 8'(RP_CYC));

    a_r2_addr_we_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_any && $past(cas_any)) |-> ($stable(dram_a) && $stable(dram_we_n)));

    a_r9_cbr_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_ras_n && cas_any) |-> (cas_both && dram_we_n && dram_oe_n && !dram_dq_oe));

    a_r4_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (dram_oe_n && !dram_we_n));

    a_r5_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);

    a_r9_gnt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |=> !ref_gnt);

    a_r9_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> !req_ready);
endmodule

bind edo_page_ctrl edo_page_ctrl_checker #(.RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n),
    .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_oe(dram_dq_oe), .dram_a(dram_a), .rdata_valid(rdata_valid),
    .ref_req(ref_req), .ref_gnt(ref_gnt), .req_ready(req_ready)
);

// File: tb/edo_page_ctrl_test.sv
`timescale 1ns/1ps
module edo_page_ctrl_test;
    localparam int B_CAS = (25 + 7) / 8;
    localparam int B_RCD = (25 + 7) / 8;
    localparam int B_RP  = (30 + 7) / 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
    logic [21:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] dram_dq_in = 16'hDEAD;
    logic        req_ready, rdata_valid, ref_gnt;
    logic [15:0] rdata, dram_dq_out;
    logic [11:0] dram_a;
    logic        dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;

    always #4 clk = ~clk;

    edo_page_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rdata(rdata), .rdata_valid(rdata_valid), .ref_req(ref_req), .ref_gnt(ref_gnt),
        .dram_a(dram_a), .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n),
        .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int n_chk = 0, n_fail = 0;
    int ras_falls = 0, cbr_cnt = 0, gnt_cnt = 0;
    logic [15:0] mem [int];
    logic [15:0] shadow [int];
    logic [15:0] exp_q [$];
    logic [25:0] key_q [$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int k);
        return k[15:0] ^ 16'hA5C3;
    endfunction

    // DRAM model and pin monitor
    logic       prev_ras = 1'b1, prev_we = 1'b1, first_col = 1'b0, in_acc = 1'b0;
    logic [1:0] prev_cas = 2'b11;
    logic [11:0] row_l = '0;
    int hi = 100, r2c = 0, clen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            logic [1:0] cas_now;
            cas_now = {dram_ucas_n, dram_lcas_n};
            if (!prev_ras && !dram_ras_n) r2c++;
            if (prev_ras && !dram_ras_n) begin
                if (cas_now == 2'b00) begin
                    cbr_cnt++;
                    chk(dram_we_n && dram_oe_n && !dram_dq_oe, "R9 cbr pins quiet",
                        {dram_we_n, dram_oe_n, dram_dq_oe}, 3'b110);
                end else begin
                    ras_falls++;
                    row_l = dram_a;
                    r2c = 0;
                    first_col = 1'b1;
                    chk(hi >= B_RP, "R6 ras precharge", hi, B_RP);
                end
            end
            if (dram_ras_n) hi++; else hi = 0;
            if (in_acc && cas_now != 2'b11) clen++;
            if (in_acc && prev_cas != 2'b11 && cas_now == 2'b11) begin
                chk(clen == B_CAS, "R5 cas width", clen, B_CAS);
                in_acc = 1'b0;
            end
            if (!dram_ras_n && prev_cas == 2'b11 && cas_now != 2'b11) begin
                logic [25:0] key;
                int k;
                key = (key_q.size() > 0) ? key_q.pop_front() : 26'h3FFFFFF;
                chk({~cas_now, row_l, dram_a} == key, "R2 R3 row/col/lanes",
                    {~cas_now, row_l, dram_a}, key);
                if (first_col) chk(r2c >= B_RCD + 1, "R6 ras to cas", r2c, B_RCD + 1);
                first_col = 1'b0;
                k = {row_l, dram_a[9:0]};
                if (!mem.exists(k)) mem[k] = pat(k);
                if (!dram_we_n) begin
                    chk(!prev_we && dram_dq_oe && dram_oe_n, "R4 early write setup",
                        {prev_we, dram_dq_oe, dram_oe_n}, 3'b011);
                    if (!cas_now[0]) mem[k][7:0]  = dram_dq_out[7:0];
                    if (!cas_now[1]) mem[k][15:8] = dram_dq_out[15:8];
                end else begin
                    chk(!dram_oe_n, "R5 oe low on read", dram_oe_n, 0);
                    dram_dq_in <= mem[k];
                end
                in_acc = 1'b1;
                clen = 1;
            end
            if (ref_gnt) gnt_cnt++;
            if (rdata_valid) begin
                logic [15:0] e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hxxxx;
                chk(rdata === e, "R3 R5 read data", rdata, e);
            end
            prev_ras = dram_ras_n;
            prev_cas = cas_now;
            prev_we  = dram_we_n;
        end
    end

    task automatic do_req(input bit wr, input logic [21:0] addr, input logic [1:0] be,
                          input logic [15:0] wd, output int waited);
        int k;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
        #1;
        waited = 0;
        while (!req_ready) begin
            @(negedge clk); #1; waited++;
        end
        k = addr;
        if (!shadow.exists(k)) shadow[k] = pat(k);
        key_q.push_back({be, addr[21:10], 2'b00, addr[9:0]});
        if (wr) begin
            if (be[0]) shadow[k][7:0]  = wd[7:0];
            if (be[1]) shadow[k][15:8] = wd[15:8];
        end else begin
            exp_q.push_back({be[1] ? shadow[k][15:8] : 8'h00, be[0] ? shadow[k][7:0] : 8'h00});
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [21:0] adr(input int row, input int col);
        return {row[11:0], col[9:0]};
    endfunction

    initial begin
        int w, rf, blocked;
        repeat (3) @(negedge clk);
        chk({dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n} == 5'h1F,
            "R1 strobes high in reset", {dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n}, 5'h1F);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dram_dq_oe && !rdata_valid, "R1 bus idle", {dram_dq_oe, rdata_valid}, 0);
        chk(req_ready, "R1 ready after reset", req_ready, 1);
        chk(dram_ras_n && dram_lcas_n && dram_ucas_n, "R1 strobes high after reset",
            {dram_ras_n, dram_lcas_n, dram_ucas_n}, 3'b111);

        // R7 page hits with mixed reads and writes on row 3
        rf = ras_falls;
        do_req(1, adr(3, 10), 2'b11, 16'h1234, w);
        do_req(0, adr(3, 10), 2'b11, 0, w);
        do_req(0, adr(3, 10), 2'b01, 0, w);
        do_req(0, adr(3, 10), 2'b10, 0, w);
        do_req(1, adr(3, 10), 2'b10, 16'hABCD, w);
        do_req(0, adr(3, 10), 2'b11, 0, w);
        do_req(0, adr(3, 1023), 2'b11, 0, w);
        repeat (8) @(negedge clk);
        chk(ras_falls - rf == 1, "R7 one row open for page", ras_falls - rf, 1);

        // R8 page miss
        rf = ras_falls;
        do_req(0, adr(7, 0), 2'b11, 0, w);
        chk(w > 0, "R8 ready held low on miss", w, 1);
        do_req(0, adr(3, 10), 2'b11, 0, w);
        repeat (8) @(negedge clk);
        chk(ras_falls - rf == 2, "R8 one ras fall per miss", ras_falls - rf, 2);

        // R9 refresh with a page open
        rf = ras_falls;
        rdata_valid_unused(blocked);
        @(negedge clk);
        ref_req = 1'b1; #1;
        blocked = 1;
        while (!ref_gnt) begin
            if (req_ready) blocked = 0;
            @(negedge clk); #1;
        end
        ref_req = 1'b0;
        chk(blocked == 1, "R9 no accept during refresh", blocked, 1);
        repeat (6) @(negedge clk);
        chk(cbr_cnt == 1 && gnt_cnt == 1, "R9 one cbr and one grant", {cbr_cnt[15:0], gnt_cnt[15:0]}, 32'h0001_0001);
        do_req(0, adr(3, 10), 2'b11, 0, w);
        repeat (8) @(negedge clk);
        chk(ras_falls - rf == 1, "R9 row reopened after refresh", ras_falls - rf, 1);

        // mixed sweep over several rows
        for (int i = 0; i < 12; i++)
            do_req(1, adr(20 + i % 3, i * 37), 2'(i % 3 + 1), 16'(i * 16'h1111 + 5), w);
        for (int i = 0; i < 12; i++)
            do_req(0, adr(20 + i % 3, i * 37), 2'b11, 0, w);
        repeat (30) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);
        chk(key_q.size() == 0, "R2 all columns strobed", key_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic rdata_valid_unused(output int z);
        z = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule